// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which message object, out of a bank of configurable objects, takes a CAN frame that has just been received. A frame header (identifier, extended-format flag, remote-frame flag and data length code) enters through a valid/ready handshake. The block then walks the object bank one entry per clock cycle, starting at index 0, and stops at the first entry that accepts the frame or after the last entry. It then raises a one-cycle `done` strobe. With it come the winning index, a hit flag, the identifier and format to write back into that object, whether the data bytes are to be stored, and whether the object's transmit request is to be set.

Each object has an enable bit, a direction bit (1 = transmit object, 0 = receive object), a 29-bit identifier and a format bit, a 29-bit identifier mask, a format mask bit, a use-mask enable and a remote-answer enable. The bank is plain configuration input. It must stay stable from the acceptance of a frame until its `done` strobe.

Back-pressure: `rx_ready` is high only while no scan is in progress. A frame transfers on a rising edge where `rx_valid` and `rx_ready` are both high. The sender must hold the header stable while `rx_valid` is high and `rx_ready` is low. `rx_ready` returns high in the cycle in which `done` is high, so the next frame can transfer on the following edge. Results hold their values until the next `done`.

Top module: `can_accept_filter`

## Requirements
- R1: For a standard frame (`rx_ext` = 0), only identifier bits 28:18 take part in the comparison. Bits 17:0 of both the received and the stored identifier are ignored.
- R2: When a standard frame hits, `wb_id[17:0]` is zero, `wb_id[28:18]` carries the 11-bit identifier, and `wb_ext` is 0.
- R3: With `obj_use_mask` set, an identifier bit whose mask bit is 0 is not compared, and `wb_id` carries the received value in that bit. A mask bit of 1 requires equality.
- R4: With `obj_use_mask` clear, every compared identifier bit and the format bit must be equal for a hit.
- R5: A data frame (`rx_rtr` = 0) can hit only receive objects (direction 0). A hit then gives `wb_data` = 1, `set_tx_req` = 0 and `wb_dlc` = `rx_dlc`.
- R6: A remote frame (`rx_rtr` = 1) hits a receive object only when that object has `obj_use_mask` set. A hit then gives `wb_data` = 0 and `set_tx_req` = 0, with `wb_dlc` and `wb_id` updated.
- R7: A remote frame hits a transmit object only when its `obj_remote_en` is set, and then `set_tx_req` = 1 and `wb_data` = 0. A transmit object with `obj_remote_en` clear never hits.
- R8: When several objects would accept the frame, `hit_idx` is the lowest such index.
- R9: An object with `obj_en` clear never hits. When no object hits, `done` comes with `hit`, `set_tx_req`, `wb_data`, `wb_ext`, `wb_dlc`, `wb_id` and `hit_idx` all zero.
- R10: Object j is compared in the j-th cycle after acceptance. `done` is high for exactly one cycle, one edge after the cycle that compared the winning object, or the last object on a miss. `rx_ready` is low from acceptance until that `done` cycle, and the result outputs change only when `done` rises.
- R11: With `obj_use_mask` set and `obj_mask_ext` = 0, the format bit is not compared. The comparison range still follows the received format, and `wb_ext` takes the received format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Frame header valid |
| rx_ready | output | 1 | Block idle, can take a header |
| rx_id | input | 29 | Received identifier (standard in 28:18) |
| rx_ext | input | 1 | Received frame is extended format |
| rx_rtr | input | 1 | Received frame is a remote frame |
| rx_dlc | input | 4 | Received data length code |
| obj_en | input | NUM_OBJ | Per-object enable |
| obj_tx | input | NUM_OBJ | Per-object direction, 1 = transmit |
| obj_ext | input | NUM_OBJ | Per-object format bit |
| obj_id | input | NUM_OBJ*29 | Per-object identifier, object i at [i*29 +: 29] |
| obj_mask | input | NUM_OBJ*29 | Per-object identifier mask, 1 = must match |
| obj_mask_ext | input | NUM_OBJ | Per-object format mask, 1 = must match |
| obj_use_mask | input | NUM_OBJ | Per-object mask enable |
| obj_remote_en | input | NUM_OBJ | Per-object remote-answer enable |
| done | output | 1 | One-cycle end-of-scan strobe |
| hit | output | 1 | An object accepted the frame |
| hit_idx | output | IDX_W | Index of the accepting object |
| wb_id | output | 29 | Identifier to write back |
| wb_ext | output | 1 | Format to write back |
| wb_dlc | output | 4 | DLC to write back |
| wb_data | output | 1 | Store the data bytes |
| set_tx_req | output | 1 | Set the object's transmit request |

## Verification
Every result is due together: `done` and the result outputs appear on the second falling edge after the accepting rising edge for a hit at object 0. Each further object compared adds one cycle, so a hit at index j shows at falling edge j+2 and a miss at falling edge NUM_OBJ+1. The bench counts falling edges from the acceptance edge and compares the count with that figure. It reads every result only at the falling edge where `done` is high. A back-pressure case holds a second header on the input during a long scan and checks that it is taken only after the first result.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int DLC_W = 4;
  localparam int LOW_W = ID_W - STD_W;

  // bits that a standard-format frame compares
  localparam logic [ID_W-1:0] STD_RANGE = {{STD_W{1'b1}}, {LOW_W{1'b0}}};

  typedef struct packed {
    logic            en;
    logic            tx;
    logic            ext;
    logic            mask_ext;
    logic            use_mask;
    logic            remote_en;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] mask;
  } obj_t;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic             ext;
    logic             rtr;
    logic [DLC_W-1:0] dlc;
  } hdr_t;
endpackage

// File: rtl/can_af_obj_sel.sv
module can_af_obj_sel
  import can_af_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int IDX_W   = 3
) (
  input  logic [IDX_W-1:0]        sel,
  input  logic [NUM_OBJ-1:0]      obj_en,
  input  logic [NUM_OBJ-1:0]      obj_tx,
  input  logic [NUM_OBJ-1:0]      obj_ext,
  input  logic [NUM_OBJ*ID_W-1:0] obj_id,
  input  logic [NUM_OBJ*ID_W-1:0] obj_mask,
  input  logic [NUM_OBJ-1:0]      obj_mask_ext,
  input  logic [NUM_OBJ-1:0]      obj_use_mask,
  input  logic [NUM_OBJ-1:0]      obj_remote_en,
  output obj_t                    obj
);
  obj_t bank [NUM_OBJ];

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_unpack
    assign bank[i].en        = obj_en[i];
    assign bank[i].tx        = obj_tx[i];
    assign bank[i].ext       = obj_ext[i];
    assign bank[i].mask_ext  = obj_mask_ext[i];
    assign bank[i].use_mask  = obj_use_mask[i];
    assign bank[i].remote_en = obj_remote_en[i];
    assign bank[i].id        = obj_id[i*ID_W +: ID_W];
    assign bank[i].mask      = obj_mask[i*ID_W +: ID_W];
  end

  assign obj = bank[sel];
endmodule

// File: rtl/can_af_obj_cmp.sv
module can_af_obj_cmp
  import can_af_pkg::*;
(
  input  hdr_t            hdr,
  input  obj_t            obj,
  output logic            hit,
  output logic            set_tx,
  output logic [ID_W-1:0] wb_id
);
  logic [ID_W-1:0] care;
  logic [ID_W-1:0] span;
  logic [ID_W-1:0] merged;
  logic            id_ok;
  logic            fmt_ok;
  logic            dir_ok;

  always_comb begin
    care   = obj.use_mask ? obj.mask : '1;
    span   = hdr.ext ? '1 : STD_RANGE;
    id_ok  = ((hdr.id ^ obj.id) & care & span) == '0;
    fmt_ok = (obj.use_mask && !obj.mask_ext) || (hdr.ext == obj.ext);
    // direction always takes part: data -> receive objects only,
    // remote -> answering transmit objects or masked receive objects
    if (hdr.rtr) dir_ok = obj.tx ? obj.remote_en : obj.use_mask;
    else         dir_ok = !obj.tx;
    hit    = obj.en && id_ok && fmt_ok && dir_ok;
    set_tx = hit && hdr.rtr && obj.tx;
    merged = (obj.id & care) | (hdr.id & ~care);
    wb_id  = merged & span;
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_af_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic [ID_W-1:0]         rx_id,
  input  logic                    rx_ext,
  input  logic                    rx_rtr,
  input  logic [DLC_W-1:0]        rx_dlc,
  input  logic [NUM_OBJ-1:0]      obj_en,
  input  logic [NUM_OBJ-1:0]      obj_tx,
  input  logic [NUM_OBJ-1:0]      obj_ext,
  input  logic [NUM_OBJ*ID_W-1:0] obj_id,
  input  logic [NUM_OBJ*ID_W-1:0] obj_mask,
  input  logic [NUM_OBJ-1:0]      obj_mask_ext,
  input  logic [NUM_OBJ-1:0]      obj_use_mask,
  input  logic [NUM_OBJ-1:0]      obj_remote_en,
  output logic                    done,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx,
  output logic [ID_W-1:0]         wb_id,
  output logic                    wb_ext,
  output logic [DLC_W-1:0]        wb_dlc,
  output logic                    wb_data,
  output logic                    set_tx_req
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OBJ - 1);

  typedef enum logic {S_IDLE, S_SCAN} state_e;

  state_e          state;
  logic [IDX_W-1:0] idx;
  hdr_t            hdr_q;
  obj_t            cur_obj;
  logic            cur_hit;
  logic            cur_tx;
  logic [ID_W-1:0] cur_wb;
  logic            finish;

  assign rx_ready = (state == S_IDLE);
  assign finish   = (state == S_SCAN) && (cur_hit || idx == LAST_IDX);

  can_af_obj_sel #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_sel (
    .sel          (idx),
    .obj_en       (obj_en),
    .obj_tx       (obj_tx),
    .obj_ext      (obj_ext),
    .obj_id       (obj_id),
    .obj_mask     (obj_mask),
    .obj_mask_ext (obj_mask_ext),
    .obj_use_mask (obj_use_mask),
    .obj_remote_en(obj_remote_en),
    .obj          (cur_obj)
  );

  can_af_obj_cmp u_cmp (
    .hdr   (hdr_q),
    .obj   (cur_obj),
    .hit   (cur_hit),
    .set_tx(cur_tx),
    .wb_id (cur_wb)
  );

  // scan sequencer: one object per cycle, stop at first hit or last object
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      hdr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (rx_valid) begin
          state <= S_SCAN;
          idx   <= '0;
          hdr_q <= '{id: rx_id, ext: rx_ext, rtr: rx_rtr, dlc: rx_dlc};
        end
        S_SCAN: begin
          if (finish) state <= S_IDLE;
          else        idx   <= idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // result registers, loaded once per scan
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      hit        <= 1'b0;
      hit_idx    <= '0;
      wb_id      <= '0;
      wb_ext     <= 1'b0;
      wb_dlc     <= '0;
      wb_data    <= 1'b0;
      set_tx_req <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        hit        <= cur_hit;
        hit_idx    <= cur_hit ? idx : '0;
        wb_id      <= cur_hit ? cur_wb : '0;
        wb_ext     <= cur_hit && hdr_q.ext;
        wb_dlc     <= cur_hit ? hdr_q.dlc : '0;
        wb_data    <= cur_hit && !hdr_q.rtr;
        set_tx_req <= cur_tx;
      end
    end
  end

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> !rx_ready);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hit) && $stable(hit_idx) && $stable(set_tx_req));

  p_std_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit && !wb_ext |-> wb_id[LOW_W-1:0] == '0);

  p_txreq_remote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_tx_req |-> hit && !wb_data);

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> !set_tx_req && !wb_data && wb_id == '0 && hit_idx == '0);
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int IW  = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [IW-1:0] rx_id = '0;
  logic rx_ext = 1'b0, rx_rtr = 1'b0;
  logic [3:0] rx_dlc = '0;
  logic [N-1:0] obj_en = '0, obj_tx = '0, obj_ext = '0;
  logic [N-1:0] obj_mask_ext = '0, obj_use_mask = '0, obj_remote_en = '0;
  logic [N*IW-1:0] obj_id = '0, obj_mask = '0;
  logic done, hit, wb_ext, wb_data, set_tx_req;
  logic [2:0] hit_idx;
  logic [IW-1:0] wb_id;
  logic [3:0] wb_dlc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter #(.NUM_OBJ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc),
    .obj_en(obj_en), .obj_tx(obj_tx), .obj_ext(obj_ext), .obj_id(obj_id),
    .obj_mask(obj_mask), .obj_mask_ext(obj_mask_ext), .obj_use_mask(obj_use_mask),
    .obj_remote_en(obj_remote_en), .done(done), .hit(hit), .hit_idx(hit_idx),
    .wb_id(wb_id), .wb_ext(wb_ext), .wb_dlc(wb_dlc), .wb_data(wb_data),
    .set_tx_req(set_tx_req)
  );

  function automatic logic [IW-1:0] sid(input logic [10:0] v);
    return {v, 18'h0};
  endfunction

  typedef struct packed {
    logic [IW-1:0] id; logic ext; logic rtr; logic [3:0] dlc;
    logic x_hit; logic [2:0] x_idx; logic [IW-1:0] x_wb; logic x_wext;
    logic x_data; logic x_tx; logic [7:0] tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R1/R2: std frame, garbage low bits ignored, zeroed in write-back
    '{29'h48C02A5, 1'b0, 1'b0, 4'd8, 1'b1, 3'd0, 29'h48C0000, 1'b0, 1'b1, 1'b0, 8'd1},
    // R3: masked low nibble taken from frame
    '{29'h1ABCDE7, 1'b1, 1'b0, 4'd3, 1'b1, 3'd1, 29'h1ABCDE7, 1'b1, 1'b1, 1'b0, 8'd3},
    // R3: care bit 4 differs -> miss
    '{29'h1ABCDF7, 1'b1, 1'b0, 4'd3, 1'b0, 3'd0, 29'h0, 1'b0, 1'b0, 1'b0, 8'd3},
    // R7: remote frame answered by transmit object
    '{29'h11580000, 1'b0, 1'b1, 4'd2, 1'b1, 3'd2, 29'h11580000, 1'b0, 1'b0, 1'b1, 8'd7},
    // R7: remote-answer disabled -> miss
    '{29'h115C0000, 1'b0, 1'b1, 4'd2, 1'b0, 3'd0, 29'h0, 1'b0, 1'b0, 1'b0, 8'd7},
    // R5: data frame never hits a transmit object
    '{29'h11580000, 1'b0, 1'b0, 4'd5, 1'b0, 3'd0, 29'h0, 1'b0, 1'b0, 1'b0, 8'd5},
    // R6: remote frame on masked receive object
    '{29'h1C280000, 1'b0, 1'b1, 4'd6, 1'b1, 3'd4, 29'h1C280000, 1'b0, 1'b0, 1'b0, 8'd6},
    // R3: data frame through the same masked object
    '{29'h1C2C0000, 1'b0, 1'b0, 4'd7, 1'b1, 3'd4, 29'h1C2C0000, 1'b0, 1'b1, 1'b0, 8'd3},
    // R9: disabled object 5 skipped, object 6 taken
    '{29'h15540000, 1'b0, 1'b0, 4'd1, 1'b1, 3'd6, 29'h15540000, 1'b0, 1'b1, 1'b0, 8'd9},
    // R11: format don't-care, extended frame on standard object
    '{29'hF012345, 1'b1, 1'b0, 4'd4, 1'b1, 3'd7, 29'hF012345, 1'b1, 1'b1, 1'b0, 8'd11},
    // R4: format differs without mask -> miss
    '{29'h48C0000, 1'b1, 1'b0, 4'd8, 1'b0, 3'd0, 29'h0, 1'b0, 1'b0, 1'b0, 8'd4},
    // R6: remote frame on unmasked receive object -> miss
    '{29'h48C0000, 1'b0, 1'b1, 4'd8, 1'b0, 3'd0, 29'h0, 1'b0, 1'b0, 1'b0, 8'd6},
    // R6: remote frame on masked receive object 7
    '{29'hF000000, 1'b0, 1'b1, 4'd0, 1'b1, 3'd7, 29'hF000000, 1'b0, 1'b0, 1'b0, 8'd6}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_obj(input int i, input logic en, input logic tx, input logic ext,
                         input logic [IW-1:0] id, input logic [IW-1:0] msk,
                         input logic mext, input logic um, input logic re);
    obj_en[i] = en; obj_tx[i] = tx; obj_ext[i] = ext;
    obj_id[i*IW +: IW] = id; obj_mask[i*IW +: IW] = msk;
    obj_mask_ext[i] = mext; obj_use_mask[i] = um; obj_remote_en[i] = re;
  endtask

  // present one header; returns falling edges from acceptance to done
  task automatic run(input logic [IW-1:0] id, input logic ext, input logic rtr,
                     input logic [3:0] dlc, output int n);
    @(negedge clk);
    rx_id = id; rx_ext = ext; rx_rtr = rtr; rx_dlc = dlc; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_result(input string req, input int n, input logic xh,
                               input logic [2:0] xi, input logic [IW-1:0] xw,
                               input logic xe, input logic [3:0] xd,
                               input logic xdat, input logic xtx);
    int lat;
    lat = xh ? int'(xi) + 2 : N + 1;
    check(n == lat, req, "latency", n, lat);
    check(hit == xh, req, "hit", hit, xh);
    check(hit_idx == (xh ? xi : 3'd0), req, "hit_idx", hit_idx, xh ? xi : 3'd0);
    check(wb_id == xw, req, "wb_id", wb_id, xw);
    check(wb_ext == xe, req, "wb_ext", wb_ext, xe);
    check(wb_dlc == (xh ? xd : 4'd0), req, "wb_dlc", wb_dlc, xh ? xd : 4'd0);
    check(wb_data == xdat, req, "wb_data", wb_data, xdat);
    check(set_tx_req == xtx, req, "set_tx_req", set_tx_req, xtx);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // object bank
    set_obj(0, 1, 0, 0, sid(11'h123), '0, 0, 0, 0);
    set_obj(1, 1, 0, 1, 29'h1ABCDE0, 29'h1FFFFFF0, 1, 1, 0);
    set_obj(2, 1, 1, 0, sid(11'h456), '0, 0, 0, 1);
    set_obj(3, 1, 1, 0, sid(11'h457), '0, 0, 0, 0);
    set_obj(4, 1, 0, 0, sid(11'h700), sid(11'h7F0), 1, 1, 0);
    set_obj(5, 0, 0, 0, sid(11'h555), '0, 0, 0, 0);
    set_obj(6, 1, 0, 0, sid(11'h555), '0, 0, 0, 0);
    set_obj(7, 1, 0, 0, sid(11'h3C0), sid(11'h7FF), 0, 1, 0);

    repeat (3) @(negedge clk);
    check(rx_ready == 1'b1, "R10", "reset rx_ready", rx_ready, 1);
    check(done == 1'b0, "R10", "reset done", done, 0);
    check(hit == 1'b0, "R9", "reset hit", hit, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string req;
      req = $sformatf("R%0d vec%0d", VEC[v].tag, v);
      run(VEC[v].id, VEC[v].ext, VEC[v].rtr, VEC[v].dlc, n);
      expect_result(req, n, VEC[v].x_hit, VEC[v].x_idx, VEC[v].x_wb,
                    VEC[v].x_wext, VEC[v].dlc, VEC[v].x_data, VEC[v].x_tx);
    end

    // R10: back-pressure, second header held during a long scan
    @(negedge clk);
    rx_id = sid(11'h555); rx_ext = 0; rx_rtr = 0; rx_dlc = 4'd2; rx_valid = 1;
    @(negedge clk);
    rx_id = sid(11'h123); rx_dlc = 4'd9;
    check(rx_ready == 1'b0, "R10", "ready during scan", rx_ready, 0);
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    check(hit_idx == 3'd6, "R10", "first result idx", hit_idx, 6);
    check(wb_dlc == 4'd2, "R10", "first result dlc", wb_dlc, 2);
    @(negedge clk);
    rx_valid = 0;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    check(hit_idx == 3'd0 && hit, "R10", "second result idx", hit_idx, 0);
    check(wb_dlc == 4'd9, "R10", "second result dlc", wb_dlc, 9);

    // R8: two candidates, lower index wins
    obj_en[5] = 1'b1;
    run(sid(11'h555), 0, 0, 4'd3, n);
    expect_result("R8", n, 1, 3'd5, sid(11'h555), 0, 4'd3, 1, 0);

    // R9: only candidate disabled -> full miss
    obj_en[0] = 1'b0;
    run(sid(11'h123), 0, 0, 4'd8, n);
    expect_result("R9", n, 0, 3'd0, '0, 0, 4'd0, 0, 0);

    // R7: remote-answer turned off on object 2
    obj_remote_en[2] = 1'b0;
    run(sid(11'h456), 0, 1, 4'd1, n);
    expect_result("R7", n, 0, 3'd0, '0, 0, 4'd0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule